// File: doc/BRIEF.md
# Tenths-of-a-second stopwatch with segment and one-hot digit outputs

The block is a runner's stopwatch that counts in tenths of a second from 00.0 up to 59.9 and then rolls back to 00.0. One active-low push input starts and stops it. A clear input brings the count back to 00.0, but only while the watch is stopped. A counter of `DIV` clock cycles produces a tick enable, and the count advances by one tenth on each tick. Setting `DIV` small makes simulation fast.

The seconds are kept as two BCD digits. The tens digit runs from 0 to 5 and the ones digit from 0 to 9. Each of these digits is driven out as a 7-segment pattern. The tenths digit is held in a 10-bit ring and is driven out as a one-hot vector. Debouncing the push input and assigning physical pins are left to the surrounding design.

Top module: `sport_timer`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the watch is stopped and shows 00.0. Both segment outputs equal 7'b0111111 and `tenths_oh_o` equals 10'b0000000001.
- R2: Each high-to-low transition of `run_btn_ni` toggles the watch between running and stopped exactly once. Holding the input low does not toggle it again.
- R3: While running, the tenths value advances by one every `DIV` clock cycles. While stopped, all outputs hold their values.
- R4: `tenths_oh_o` always has exactly one bit set, and bit k is set for tenths value k (0 to 9).
- R5: When the tenths value steps from 9 to 0, the seconds value increases by one in the same step.
- R6: The seconds value counts 0 to 59 as a tens BCD digit (0 to 5) and a ones BCD digit (0 to 9). The display rolls over from 59.9 to 00.0.
- R7: The segment outputs use bit order {g,f,e,d,c,b,a}, active high. Digits 0 to 9 encode as 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R8: When `clear_i` is high at a clock edge while the watch is stopped, the display returns to 00.0.
- R9: When `clear_i` is high while the watch is running, it has no effect, and the count keeps advancing from its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_btn_ni | input | 1 | Active-low start/stop push input |
| clear_i | input | 1 | Clear to 00.0 (honoured only while stopped) |
| tens_seg_o | output | 7 | Tens-of-seconds digit, 7-segment {g..a} |
| ones_seg_o | output | 7 | Ones-of-seconds digit, 7-segment {g..a} |
| tenths_oh_o | output | 10 | Tenths digit, one-hot |

## Verification
Several properties are checked by assertions on every clock cycle:
- the ring stays one-hot;
- the BCD digits stay in range, and 59 wraps to 00;
- a carry steps the ones digit;
- the ring holds without a tick;
- the run state changes only after a detected press;
- a clear has no effect while running.

Other behaviours can only be shown by the bench's scenarios, which compare the full display after a measured run time:
- the exact number of tenths counted for a given running time;
- the segment codes;
- the roll-over from 59.9;
- a long press counting as a single toggle;
- a clear taking effect after the watch stops.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int SEG_W   = 7;
  localparam int DIGIT_W = 4;
  localparam int RING_N  = 10;

  // {g,f,e,d,c,b,a}, active high; non-decimal codes blank
  function automatic logic [SEG_W-1:0] seg_of(input logic [DIGIT_W-1:0] d);
    unique case (d)
      4'd0:    seg_of = 7'h3F;
      4'd1:    seg_of = 7'h06;
      4'd2:    seg_of = 7'h5B;
      4'd3:    seg_of = 7'h4F;
      4'd4:    seg_of = 7'h66;
      4'd5:    seg_of = 7'h6D;
      4'd6:    seg_of = 7'h7D;
      4'd7:    seg_of = 7'h07;
      4'd8:    seg_of = 7'h7F;
      4'd9:    seg_of = 7'h6F;
      default: seg_of = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl #(
  parameter int DIV         = 5_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic clear_i,
  output logic run_o,
  output logic tick_o,
  output logic clr_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   fall;
  logic                   run_q;
  logic [CW-1:0]          div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], btn_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else if (fall) run_q <= ~run_q;
  end

  // divider idles at zero while stopped so each run starts a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (!run_q || tick_o) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick_o = run_q && (div_q == CW'(DIV - 1));
  assign clr_o  = clear_i && !run_q;
  assign run_o  = run_q;

  assert_toggle_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(run_q) |-> $past(fall));
  assert_div_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= CW'(DIV - 1));
endmodule

// File: rtl/tenths_ring.sv
module tenths_ring #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [N-1:0] ring_o,
  output logic         carry_o
);
  logic [N-1:0] ring_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= N'(1);
    else if (clr_i) ring_q <= N'(1);
    else if (tick_i) ring_q <= {ring_q[N-2:0], ring_q[N-1]};
  end

  assign carry_o = tick_i & ring_q[N-1];
  assign ring_o  = ring_q;

  assert_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_q) == 1);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(ring_q));
endmodule

// File: rtl/bcd_sec_counter.sv
module bcd_sec_counter #(
  parameter int DW       = 4,
  parameter int ONES_MAX = 9,
  parameter int TENS_MAX = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [DW-1:0] ones_o,
  output logic [DW-1:0] tens_o
);
  logic [DW-1:0] ones_q, tens_q;
  logic          ones_top, tens_top;

  assign ones_top = ones_q == DW'(ONES_MAX);
  assign tens_top = tens_q == DW'(TENS_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      tens_q <= '0;
    end else if (clr_i) begin
      ones_q <= '0;
      tens_q <= '0;
    end else if (inc_i) begin
      if (ones_top) begin
        ones_q <= '0;
        tens_q <= tens_top ? '0 : tens_q + 1'b1;
      end else begin
        ones_q <= ones_q + 1'b1;
      end
    end
  end

  assign ones_o = ones_q;
  assign tens_o = tens_q;

  assert_bcd_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= DW'(ONES_MAX) && tens_q <= DW'(TENS_MAX));
  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && ones_top && tens_top) |=> (ones_q == '0 && tens_q == '0));
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import sw_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [SEG_W-1:0]   seg_o
);
  assign seg_o = seg_of(digit_i);
endmodule

// File: rtl/sport_timer.sv
module sport_timer
  import sw_pkg::*;
#(
  parameter int DIV         = 5_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_btn_ni,
  input  logic              clear_i,
  output logic [SEG_W-1:0]  tens_seg_o,
  output logic [SEG_W-1:0]  ones_seg_o,
  output logic [RING_N-1:0] tenths_oh_o
);
  localparam int NDIG = 2;

  logic run, tick, clr, carry;
  logic [RING_N-1:0] ring;
  logic [DIGIT_W-1:0] ones_d, tens_d;
  logic [NDIG-1:0][DIGIT_W-1:0] digs;
  logic [NDIG-1:0][SEG_W-1:0]   segs;

  sw_ctrl #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk_i, .rst_ni, .btn_ni(run_btn_ni), .clear_i,
    .run_o(run), .tick_o(tick), .clr_o(clr)
  );

  tenths_ring #(.N(RING_N)) u_ring (
    .clk_i, .rst_ni, .tick_i(tick), .clr_i(clr), .ring_o(ring), .carry_o(carry)
  );

  bcd_sec_counter #(.DW(DIGIT_W), .ONES_MAX(9), .TENS_MAX(5)) u_sec (
    .clk_i, .rst_ni, .inc_i(carry), .clr_i(clr), .ones_o(ones_d), .tens_o(tens_d)
  );

  assign digs[0] = ones_d;
  assign digs[1] = tens_d;

  for (genvar g = 0; g < NDIG; g++) begin : g_seg
    seg_decoder u_dec (.digit_i(digs[g]), .seg_o(segs[g]));
  end

  assign ones_seg_o  = segs[0];
  assign tens_seg_o  = segs[1];
  assign tenths_oh_o = ring;

  assert_clear_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && clear_i && !tick) |=> ($stable(ring) && $stable(ones_d) && $stable(tens_d)));
  assert_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ring[RING_N-1]) |=> (ones_d != $past(ones_d)));
endmodule

// File: tb/sport_timer_test.sv
module sport_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NVEC       = 6;
  // ticks to run per step, expected cumulative display in tenths (mod 600)
  localparam int VEC_TICKS [NVEC] = '{3, 7, 95, 494, 1, 23};
  localparam int VEC_EXP   [NVEC] = '{3, 10, 105, 599, 0, 23};

  logic clk = 1'b0, rst_n = 1'b0, btn_n = 1'b1, clr = 1'b0;
  logic [6:0] tens_seg, ones_seg;
  logic [9:0] tenths;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_timer #(.DIV(DIV), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_btn_ni(btn_n), .clear_i(clr),
    .tens_seg_o(tens_seg), .ones_seg_o(ones_seg), .tenths_oh_o(tenths)
  );

  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'b0111111; 1: return 7'b0000110; 2: return 7'b1011011;
      3: return 7'b1001111; 4: return 7'b1100110; 5: return 7'b1101101;
      6: return 7'b1111101; 7: return 7'b0000111; 8: return 7'b1111111;
      default: return 7'b1101111;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_disp(input string req, input int v);
    check({req, " tens"},   32'(tens_seg), 32'(exp_seg((v / 100) % 6)));
    check({req, " ones"},   32'(ones_seg), 32'(exp_seg((v / 10) % 10)));
    check({req, " tenths"}, 32'(tenths),   32'(10'(1) << (v % 10)));
  endtask

  // start, run for ticks*DIV+2 cycles between the two press edges, stop
  task automatic run_ticks(input int ticks, input int hold, input bit clr_mid);
    @(negedge clk) btn_n = 1'b0;
    repeat (hold) @(negedge clk);
    btn_n = 1'b1;
    for (int i = hold; i < ticks*DIV + 2; i++) begin
      clr = clr_mid && (i == hold + 3 || i == hold + 4);
      @(negedge clk);
    end
    clr = 1'b0;
    btn_n = 1'b0;
    repeat (2) @(negedge clk);
    btn_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_disp("R1 reset", 0);
    repeat (20) @(negedge clk);
    check("R3 idle hold", 32'(tenths), 32'h1);

    // R3 R4 R5 R6 R7: table of run lengths and cumulative display
    for (int k = 0; k < NVEC; k++) begin
      run_ticks(VEC_TICKS[k], 2, 1'b0);
      check_disp($sformatf("R3/R5/R6/R7 vec%0d", k), VEC_EXP[k]);
    end

    // R3: stopped watch holds
    snap = {tens_seg, ones_seg, tenths};
    repeat (40) @(negedge clk);
    check("R3 stopped hold", 32'({tens_seg, ones_seg, tenths}), 32'(snap));

    // R2: long press toggles once (23 + 12 = 35)
    run_ticks(12, 20, 1'b0);
    check_disp("R2 long press", 35);

    // R9: clear during run ignored (35 + 40 = 75)
    run_ticks(40, 2, 1'b1);
    check_disp("R9 clear while running", 75);

    // R8: clear while stopped
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    repeat (2) @(negedge clk);
    check_disp("R8 clear stopped", 0);

    // R4 boundary: tenths 9, then carry into seconds (R5)
    run_ticks(9, 2, 1'b0);
    check_disp("R4 tenths nine", 9);
    run_ticks(1, 2, 1'b0);
    check_disp("R5 carry", 10);

    finish_run();
  end
endmodule